// File: doc/BRIEF.md
# Load/Store Address Translation and Fault Unit

This unit handles the address half of a memory access instruction. It adds a sign-extended immediate offset to a base register value to form a virtual address. It then tests that address against a fixed chain of checks: alignment for the access size, privilege against the current CPU mode, and the result of a page table lookup (entry present, entry valid, and, for stores only, write permission). If every check passes, it builds the physical address from the returned frame number and the page offset. If a check fails, it reports exactly one fault and captures the virtual address that caused it.

The translation buffer itself sits outside the unit. The unit presents the virtual page number combinationally on a lookup port, and the outside storage answers in the same cycle with hit, valid, write-enable and frame number. A request is a single-cycle pulse on `start_i`. One clock later, `done_o` pulses and the registered result appears, either a physical address or a one-hot fault code. The result stays on the outputs until the next request.

Top module: `lsu_xlate`

## Requirements
- R1: The virtual address is `base_i` plus `imm_i` sign-extended to 32 bits, with the carry out of bit 31 dropped. Its bits 31..12 appear on `tlb_page_o` in the same cycle as the inputs, without a clock edge in between.
- R2: Only `opcode_i[2:0]` is decoded, and bits 5..3 have no effect. The encodings are: 000 word load, 001 half load, 010 half load unsigned, 011 byte load, 100 byte load unsigned, 101 word store, 110 half store, 111 byte store.
- R3: A word access with virtual address bits 1..0 not 00 raises the alignment fault, `fault_o` = 5'b00001. A half access with bit 0 set raises the same fault. A byte access never raises it.
- R4: Virtual address bit 31 set while `user_i` = 1 raises the privilege fault, `fault_o` = 5'b00010. With `user_i` = 0, such an address is not faulted for privilege.
- R5: `tlb_hit_i` = 0 raises the lookup-miss fault, `fault_o` = 5'b00100.
- R6: A hit with `tlb_valid_i` = 0 raises the invalid-entry fault, `fault_o` = 5'b01000.
- R7: A store that hits a valid entry with `tlb_write_i` = 0 raises the write-protect fault, `fault_o` = 5'b10000. For loads, `tlb_write_i` has no effect.
- R8: When several conditions hold at once, only the first in the order alignment, privilege, miss, invalid, write-protect is reported. `fault_o` never has more than one bit set.
- R9: On success, `paddr_o` = {`tlb_frame_i`, virtual address bits 11..0} and `fault_o` = 0. On a fault, `paddr_o` = 0.
- R10: `badaddr_o` takes the virtual address of every faulting request. It keeps its value across successful requests and across idle cycles.
- R11: `done_o` is 1 in exactly the cycle after `start_i` was sampled high. `paddr_o` and `fault_o` keep their values until the next request.
- R12: While `rst_n` = 0, `done_o`, `fault_o`, `paddr_o` and `badaddr_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request pulse; the other request inputs are sampled with it |
| opcode_i | input | 6 | Access opcode; the low three bits select size and direction |
| base_i | input | 32 | Base register value |
| imm_i | input | 16 | Signed immediate offset |
| user_i | input | 1 | 1 when the CPU is in user mode |
| tlb_page_o | output | 20 | Virtual page number presented for lookup |
| tlb_hit_i | input | 1 | Lookup found an entry |
| tlb_valid_i | input | 1 | Valid bit of the found entry |
| tlb_write_i | input | 1 | Write-permission bit of the found entry |
| tlb_frame_i | input | 20 | Frame number of the found entry |
| done_o | output | 1 | Result strobe, one cycle after the request |
| paddr_o | output | 32 | Physical address of the last request, or 0 if it faulted |
| fault_o | output | 5 | One-hot fault code of the last request, 0 on success |
| badaddr_o | output | 32 | Virtual address of the most recent faulting request |

## Verification
A fault that the priority logic picks wrongly shows up on `fault_o` at the very `done_o` pulse of the request that caused it. So does a fault code with more than one bit set, and so does a wrong size decode. In each case the error is visible one clock after `start_i`. A bad-address register that takes a value it should not, such as on a successful request or in an idle cycle, stays wrong until the next fault. The bench therefore reads it back after both successful requests and idle cycles. An error in the address adder appears on `tlb_page_o` in the same cycle. The same error reaches `paddr_o` or `badaddr_o` one clock later.

// File: rtl/lsx_pkg.sv
package lsx_pkg;

    localparam int FAULT_W   = 5;
    localparam int F_ALIGN   = 0;
    localparam int F_PRIV    = 1;
    localparam int F_MISS    = 2;
    localparam int F_INVALID = 3;
    localparam int F_WPROT   = 4;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef struct packed {
        acc_size_e size;
        logic      is_store;
    } acc_kind_t;

endpackage

// File: rtl/lsx_decode.sv
module lsx_decode
    import lsx_pkg::*;
(
    input  logic [2:0] op_lo_i,
    output acc_kind_t  kind_o
);

    always_comb begin
        kind_o.is_store = 1'b0;
        kind_o.size     = SZ_WORD;
        unique case (op_lo_i)
            3'b000: begin kind_o.size = SZ_WORD; kind_o.is_store = 1'b0; end
            3'b001,
            3'b010: begin kind_o.size = SZ_HALF; kind_o.is_store = 1'b0; end
            3'b011,
            3'b100: begin kind_o.size = SZ_BYTE; kind_o.is_store = 1'b0; end
            3'b101: begin kind_o.size = SZ_WORD; kind_o.is_store = 1'b1; end
            3'b110: begin kind_o.size = SZ_HALF; kind_o.is_store = 1'b1; end
            default: begin kind_o.size = SZ_BYTE; kind_o.is_store = 1'b1; end
        endcase
    end

endmodule

// File: rtl/lsx_vaddr.sv
module lsx_vaddr #(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [IMM_W-1:0]  imm_i,
    output logic [ADDR_W-1:0] vaddr_o
);

    localparam int EXT_W = ADDR_W - IMM_W;

    logic [ADDR_W-1:0] imm_ext;

    always_comb begin
        imm_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
        vaddr_o = base_i + imm_ext;
    end

endmodule

// File: rtl/lsx_fault.sv
module lsx_fault
    import lsx_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]  vaddr_i,
    input  acc_kind_t          kind_i,
    input  logic               user_i,
    input  logic               hit_i,
    input  logic               valid_i,
    input  logic               write_i,
    output logic [FAULT_W-1:0] fault_o
);

    logic [FAULT_W-1:0] raw;
    logic [FAULT_W:0]   seen;

    always_comb begin
        raw = '0;
        unique case (kind_i.size)
            SZ_WORD: raw[F_ALIGN] = |vaddr_i[1:0];
            SZ_HALF: raw[F_ALIGN] = vaddr_i[0];
            default: raw[F_ALIGN] = 1'b0;
        endcase
        raw[F_PRIV]    = vaddr_i[ADDR_W-1] & user_i;
        raw[F_MISS]    = ~hit_i;
        raw[F_INVALID] = ~valid_i;
        raw[F_WPROT]   = kind_i.is_store & ~write_i;
    end

    // First set condition in chain order wins.
    assign seen[0] = 1'b0;
    generate
        for (genvar k = 0; k < FAULT_W; k++) begin : g_prio
            assign fault_o[k]  = raw[k] & ~seen[k];
            assign seen[k+1]   = seen[k] | raw[k];
        end
    endgenerate

    // A reported code keeps at most one bit (R8).
    always_comb begin
        p_prio_onehot_r8: assert ($onehot0(fault_o));
    end

endmodule

// File: rtl/lsu_xlate.sv
module lsu_xlate
    import lsx_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 16,
    parameter int OFF_W  = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [5:0]               opcode_i,
    input  logic [ADDR_W-1:0]        base_i,
    input  logic [IMM_W-1:0]         imm_i,
    input  logic                     user_i,
    output logic [ADDR_W-OFF_W-1:0]  tlb_page_o,
    input  logic                     tlb_hit_i,
    input  logic                     tlb_valid_i,
    input  logic                     tlb_write_i,
    input  logic [ADDR_W-OFF_W-1:0]  tlb_frame_i,
    output logic                     done_o,
    output logic [ADDR_W-1:0]        paddr_o,
    output logic [FAULT_W-1:0]       fault_o,
    output logic [ADDR_W-1:0]        badaddr_o
);

    localparam int PN_W = ADDR_W - OFF_W;

    typedef struct packed {
        logic               done;
        logic [ADDR_W-1:0]  paddr;
        logic [FAULT_W-1:0] fault;
        logic [ADDR_W-1:0]  badaddr;
    } xl_state_t;

    xl_state_t          st_d, st_q;
    logic [ADDR_W-1:0]  vaddr;
    acc_kind_t          kind;
    logic [FAULT_W-1:0] fault_now;
    logic               unused_op_hi;

    assign unused_op_hi = ^opcode_i[5:3];

    lsx_decode u_decode (
        .op_lo_i (opcode_i[2:0]),
        .kind_o  (kind)
    );

    lsx_vaddr #(
        .ADDR_W (ADDR_W),
        .IMM_W  (IMM_W)
    ) u_vaddr (
        .base_i  (base_i),
        .imm_i   (imm_i),
        .vaddr_o (vaddr)
    );

    lsx_fault #(
        .ADDR_W (ADDR_W)
    ) u_fault (
        .vaddr_i (vaddr),
        .kind_i  (kind),
        .user_i  (user_i),
        .hit_i   (tlb_hit_i),
        .valid_i (tlb_valid_i),
        .write_i (tlb_write_i),
        .fault_o (fault_now)
    );

    assign tlb_page_o = vaddr[ADDR_W-1:OFF_W];

    always_comb begin
        st_d      = st_q;
        st_d.done = start_i;
        if (start_i) begin
            st_d.fault = fault_now;
            if (|fault_now) begin
                st_d.paddr   = '0;
                st_d.badaddr = vaddr;
            end else begin
                st_d.paddr = {tlb_frame_i, vaddr[OFF_W-1:0]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o    = st_q.done;
    assign paddr_o   = st_q.paddr;
    assign fault_o   = st_q.fault;
    assign badaddr_o = st_q.badaddr;

    p_done_after_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);
    p_no_spurious_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o);
    p_bad_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(badaddr_o));
    p_fault_clears_paddr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|fault_o) |-> (paddr_o == '0));
    p_code_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fault_o));
    p_idle_result_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ($stable(paddr_o) && $stable(fault_o)));

endmodule

// File: tb/lsu_xlate_tb.sv
module lsu_xlate_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [5:0]  opcode_i = '0;
    logic [31:0] base_i = '0;
    logic [15:0] imm_i = '0;
    logic        user_i = 1'b0;
    logic [19:0] tlb_page_o;
    logic        tlb_hit_i = 1'b0;
    logic        tlb_valid_i = 1'b0;
    logic        tlb_write_i = 1'b0;
    logic [19:0] tlb_frame_i = '0;
    logic        done_o;
    logic [31:0] paddr_o;
    logic [4:0]  fault_o;
    logic [31:0] badaddr_o;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_bad = '0;

    localparam logic [4:0] FA = 5'b00001, FP = 5'b00010, FM = 5'b00100,
                           FI = 5'b01000, FW = 5'b10000, FN = 5'b00000;

    always #5 clk = ~clk;

    lsu_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .opcode_i(opcode_i),
        .base_i(base_i), .imm_i(imm_i), .user_i(user_i), .tlb_page_o(tlb_page_o),
        .tlb_hit_i(tlb_hit_i), .tlb_valid_i(tlb_valid_i), .tlb_write_i(tlb_write_i),
        .tlb_frame_i(tlb_frame_i), .done_o(done_o), .paddr_o(paddr_o),
        .fault_o(fault_o), .badaddr_o(badaddr_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(input string tag, input logic [5:0] op, input logic [31:0] base,
                          input logic [15:0] imm, input logic usr, input logic hit,
                          input logic vld, input logic wr, input logic [19:0] frame,
                          input logic [4:0] exp_fault);
        logic [31:0] va;
        logic [31:0] exp_pa;
        va = base + {{16{imm[15]}}, imm};
        exp_pa = (exp_fault != 0) ? 32'h0 : {frame, va[11:0]};
        if (exp_fault != 0) exp_bad = va;
        @(negedge clk);
        opcode_i = op; base_i = base; imm_i = imm; user_i = usr;
        tlb_hit_i = hit; tlb_valid_i = vld; tlb_write_i = wr; tlb_frame_i = frame;
        start_i = 1'b1;
        #1;
        chk({tag, " R1 page"}, {12'h0, tlb_page_o}, {12'h0, va[31:12]});
        @(posedge clk);
        #2;
        chk({tag, " R11 done"}, {31'h0, done_o}, 32'h1);
        chk({tag, " fault"}, {27'h0, fault_o}, {27'h0, exp_fault});
        chk({tag, " R9 paddr"}, paddr_o, exp_pa);
        chk({tag, " R10 badaddr"}, badaddr_o, exp_bad);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        chk("R12 done", {31'h0, done_o}, 32'h0);
        chk("R12 fault", {27'h0, fault_o}, 32'h0);
        chk("R12 paddr", paddr_o, 32'h0);
        chk("R12 badaddr", badaddr_o, 32'h0);
    endtask

    task automatic t_basic();
        access("R1 R9 ldw", 6'b110000, 32'h0000_1000, 16'h0010, 0, 1, 1, 1, 20'hABCDE, FN);
        access("R1 neg imm", 6'b110000, 32'h0000_2004, 16'hFFF8, 0, 1, 1, 1, 20'h12345, FN);
        access("R1 wrap", 6'b110011, 32'hFFFF_FFFF, 16'h0002, 0, 1, 1, 1, 20'h00077, FN);
    endtask

    task automatic t_align();
        access("R3 ldw mis", 6'b110000, 32'h0000_3002, 16'h0000, 0, 1, 1, 1, 20'h1, FA);
        access("R3 ldw mis1", 6'b110101, 32'h0000_3001, 16'h0000, 0, 1, 1, 1, 20'h1, FA);
        access("R3 ldh ok", 6'b110001, 32'h0000_3002, 16'h0000, 0, 1, 1, 1, 20'h2, FN);
        access("R3 ldhu odd", 6'b110010, 32'h0000_3000, 16'h0001, 0, 1, 1, 1, 20'h2, FA);
        access("R3 sth odd", 6'b110110, 32'h0000_3003, 16'h0000, 0, 1, 1, 1, 20'h2, FA);
        access("R3 ldb odd", 6'b110011, 32'h0000_3003, 16'h0000, 0, 1, 1, 1, 20'h3, FN);
        access("R3 ldbu odd", 6'b110100, 32'h0000_3001, 16'h0000, 0, 1, 1, 1, 20'h3, FN);
        access("R3 stb odd", 6'b110111, 32'h0000_3005, 16'h0000, 0, 1, 1, 1, 20'h3, FN);
    endtask

    task automatic t_priv();
        access("R4 user hi", 6'b110000, 32'h8000_0000, 16'h0004, 1, 1, 1, 1, 20'h4, FP);
        access("R4 kernel hi", 6'b110000, 32'h8000_0000, 16'h0004, 0, 1, 1, 1, 20'h4, FN);
        access("R4 user lo", 6'b110000, 32'h7FFF_F000, 16'h0004, 1, 1, 1, 1, 20'h5, FN);
    endtask

    task automatic t_tlb();
        access("R5 miss", 6'b110000, 32'h0001_0000, 16'h0000, 0, 0, 1, 1, 20'h6, FM);
        access("R6 invalid", 6'b110100, 32'h0001_0001, 16'h0000, 0, 1, 0, 1, 20'h6, FI);
        access("R7 stw wprot", 6'b110101, 32'h0002_0000, 16'h0000, 0, 1, 1, 0, 20'h7, FW);
        access("R7 stb wprot", 6'b110111, 32'h0002_0003, 16'h0000, 0, 1, 1, 0, 20'h7, FW);
        access("R7 ld ignores wr", 6'b110000, 32'h0002_0000, 16'h0000, 0, 1, 1, 0, 20'h8, FN);
        access("R7 st ok", 6'b110110, 32'h0002_0002, 16'h0000, 0, 1, 1, 1, 20'h9, FN);
    endtask

    task automatic t_prio();
        access("R8 align first", 6'b110101, 32'h8000_0002, 16'h0000, 1, 0, 0, 0, 20'h1, FA);
        access("R8 priv second", 6'b110101, 32'h8000_0004, 16'h0000, 1, 0, 0, 0, 20'h1, FP);
        access("R8 miss third", 6'b110101, 32'h0000_0004, 16'h0000, 1, 0, 0, 0, 20'h1, FM);
        access("R8 invalid fourth", 6'b110101, 32'h0000_0004, 16'h0000, 1, 1, 0, 0, 20'h1, FI);
    endtask

    task automatic t_opcode_hi();
        access("R2 hi bits stw", 6'b000101, 32'h0003_0000, 16'h0000, 0, 1, 1, 0, 20'hA, FW);
        access("R2 hi bits ldh", 6'b011001, 32'h0003_0001, 16'h0000, 0, 1, 1, 1, 20'hA, FA);
        access("R2 hi bits ldb", 6'b101011, 32'h0003_0001, 16'h0000, 0, 1, 1, 0, 20'hB, FN);
    endtask

    task automatic t_hold();
        logic [31:0] pa;
        logic [4:0]  f;
        access("R10 fault", 6'b110000, 32'h0004_0002, 16'h0000, 0, 1, 1, 1, 20'hC, FA);
        access("R10 ok keeps bad", 6'b110000, 32'h0004_0004, 16'h0000, 0, 1, 1, 1, 20'hC, FN);
        pa = paddr_o;
        f  = fault_o;
        opcode_i = 6'b110000; base_i = 32'h0000_0002; tlb_hit_i = 1'b0; user_i = 1'b1;
        @(posedge clk);
        #2;
        chk("R11 done drop", {31'h0, done_o}, 32'h0);
        chk("R11 paddr hold", paddr_o, pa);
        chk("R11 fault hold", {27'h0, fault_o}, {27'h0, f});
        chk("R10 idle bad hold", badaddr_o, exp_bad);
    endtask

    initial begin
        #2_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_basic();
        t_align();
        t_priv();
        t_tlb();
        t_prio();
        t_opcode_hi();
        t_hold();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule